// File: doc/BRIEF.md
# Ownership-Gated Store Queue

This block holds committed-in-program-order stores between a core pipeline and the first-level cache controller. The pipeline pushes stores as soon as their address, data and byte enables are known, which may be while they are still speculative. The pipeline later marks them retired, oldest first. An exception, fault or interrupt flushes the queue. A flush discards only the stores that have not yet retired. Retired stores stay and still reach the cache. Loads look into the queue and receive forwarded data from the youngest matching store. The entry's retire and ownership state plays no part in forwarding.

Each entry asks the cache controller for ownership of its cache line. Several entries may have requests outstanding at once, and an entry may ask before it retires. A grant names a line, and every queued entry in that line is then marked owned. The oldest entry is written to the cache once it is both retired and owned. Entries are written in order, one per cycle at most. The queue never answers coherence snoops. All protocol work belongs to the cache controller.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the queue is empty. `st_ready_o` is high, and `cm_valid_o`, `own_req_valid_o`, `ld_hit_o` and `ld_stall_o` are low.
- R2: The queue holds DEPTH (8) stores. `st_ready_o` is low when it is full and in any cycle with `flush_i` high. A store with `st_valid_i` high and `st_ready_o` low is not taken.
- R3: With `ld_valid_i` high, a load's word address is compared with each queued store. If a store matches, forwarding uses the youngest matching store. If that store's byte mask covers every bit set in `ld_mask_i`, then `ld_hit_o` is high and `ld_data_o` carries that store's data. This holds whether or not the store is retired or owned.
- R4: If the youngest matching store does not cover the load's byte mask, then `ld_stall_o` is high and `ld_hit_o` is low. With no match, or with `ld_valid_i` low, both are low.
- R5: `cm_valid_o` is high only when the oldest entry is both retired and owned. An entry leaves the queue when `cm_valid_o` and `cm_ready_i` are both high, so at most one entry leaves per cycle.
- R6: Retiring a store does not remove it. A retired store that is not owned stays in the queue and keeps forwarding.
- R7: `flush_i` drops every entry that has not retired. Retired entries remain and still drain.
- R8: Stores reach the commit port in the order they were accepted, with the address, data and mask they were accepted with.
- R9: `own_req_valid_o` presents the oldest entry that is neither owned nor has already sent a request. `own_req_line_o` carries that entry's line, which is the store address with its low LINE_W (2) bits dropped. The request is held until `own_req_ready_i`, and it may be for an entry that has not retired. After the handshake the next such entry is offered, so several requests can be outstanding.
- R10: When `own_gnt_valid_i` is high, every queued entry whose line equals `own_gnt_line_i` becomes owned. This includes a store accepted in that same cycle.
- R11: A grant for a line with no queued entry, such as one whose entries were flushed, has no effect. A later store to that line must request ownership again.
- R12: `retire_i` retires the oldest unretired entry. If a retire and a flush arrive in the same cycle, the retire takes effect first. A retire with no unretired entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered by pipeline |
| st_ready_o | output | 1 | Queue can take a store |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| st_mask_i | input | DW/8 | Store byte enables |
| retire_i | input | 1 | Retire the oldest unretired store |
| flush_i | input | 1 | Drop all unretired stores |
| ld_valid_i | input | 1 | Load lookup valid |
| ld_addr_i | input | AW | Load word address |
| ld_mask_i | input | DW/8 | Load byte enables |
| ld_hit_o | output | 1 | Load fully served by forwarding |
| ld_stall_o | output | 1 | Load partly covered, must wait |
| ld_data_o | output | DW | Forwarded data |
| own_req_valid_o | output | 1 | Ownership request valid |
| own_req_ready_i | input | 1 | Controller accepts request |
| own_req_line_o | output | AW-LINE_W | Requested line |
| own_gnt_valid_i | input | 1 | Ownership granted |
| own_gnt_line_i | input | AW-LINE_W | Granted line |
| cm_valid_o | output | 1 | Head store ready to write |
| cm_ready_i | input | 1 | Cache write port ready |
| cm_addr_o | output | AW | Commit address |
| cm_data_o | output | DW | Commit data |
| cm_mask_o | output | DW/8 | Commit byte enables |

## Verification
The hardest case to reach from the ports is a queue that holds retired but unowned stores, unretired stores, requests already sent and a late grant, all at the same moment. Only then do the flush, grant and drain rules interact. The stimulus first fills the queue and lets requests go out without grants. It then retires part of the queue and flushes, and only after that grants the lines, including lines whose entries were flushed. Other sequences cover a retire and a flush in the same cycle, and a grant in the same cycle as a store to that line. A long random phase follows, with addresses confined to a few lines and grants biased toward lines that have outstanding requests. The reference model is compared on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_DEPTH  = 8;
  localparam int unsigned SB_AW     = 16;
  localparam int unsigned SB_DW     = 32;
  localparam int unsigned SB_LINE_W = 2;

  typedef struct packed {
    logic owned;
    logic asked;
  } sb_flags_t;
endpackage

// File: rtl/sb_fwd_unit.sv
module sb_fwd_unit #(
  parameter int unsigned DEPTH = sb_pkg::SB_DEPTH,
  parameter int unsigned AW    = sb_pkg::SB_AW,
  parameter int unsigned DW    = sb_pkg::SB_DW,
  localparam int unsigned MW   = DW / 8
) (
  input  logic [DEPTH-1:0] vld_i,          // age order, 0 = oldest
  input  logic [AW-1:0]    addr_i [DEPTH],
  input  logic [DW-1:0]    data_i [DEPTH],
  input  logic [MW-1:0]    mask_i [DEPTH],
  input  logic             ld_valid_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [MW-1:0]    ld_mask_i,
  output logic             hit_o,
  output logic             stall_o,
  output logic [DW-1:0]    data_o
);
  logic          found;
  logic [DW-1:0] sel_data;
  logic [MW-1:0] sel_mask;
  logic          covered;

  // scan oldest to youngest, last match wins
  always_comb begin
    found    = 1'b0;
    sel_data = '0;
    sel_mask = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (vld_i[k] && addr_i[k] == ld_addr_i) begin
        found    = 1'b1;
        sel_data = data_i[k];
        sel_mask = mask_i[k];
      end
    end
  end

  assign covered = (ld_mask_i & ~sel_mask) == '0;
  assign hit_o   = ld_valid_i && found && covered;
  assign stall_o = ld_valid_i && found && !covered;
  assign data_o  = hit_o ? sel_data : '0;
endmodule

// File: rtl/sb_req_pick.sv
module sb_req_pick #(
  parameter int unsigned DEPTH  = sb_pkg::SB_DEPTH,
  parameter int unsigned AW     = sb_pkg::SB_AW,
  parameter int unsigned LINE_W = sb_pkg::SB_LINE_W,
  localparam int unsigned IW    = $clog2(DEPTH),
  localparam int unsigned LW    = AW - LINE_W
) (
  input  logic [DEPTH-1:0]       vld_i,     // age order, 0 = oldest
  input  sb_pkg::sb_flags_t      flags_i [DEPTH],
  input  logic [AW-1:0]          addr_i  [DEPTH],
  output logic                   req_valid_o,
  output logic [IW-1:0]          req_age_o,
  output logic [LW-1:0]          req_line_o
);
  always_comb begin
    req_valid_o = 1'b0;
    req_age_o   = '0;
    req_line_o  = '0;
    // descending scan so the oldest candidate is taken last
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (vld_i[k] && !flags_i[k].owned && !flags_i[k].asked) begin
        req_valid_o = 1'b1;
        req_age_o   = IW'(k);
        req_line_o  = addr_i[k][AW-1:LINE_W];
      end
    end
  end
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer #(
  parameter int unsigned DEPTH  = sb_pkg::SB_DEPTH,   // power of two
  parameter int unsigned AW     = sb_pkg::SB_AW,
  parameter int unsigned DW     = sb_pkg::SB_DW,
  parameter int unsigned LINE_W = sb_pkg::SB_LINE_W,
  localparam int unsigned MW    = DW / 8,
  localparam int unsigned LW    = AW - LINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [MW-1:0] st_mask_i,
  input  logic          retire_i,
  input  logic          flush_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [MW-1:0] ld_mask_i,
  output logic          ld_hit_o,
  output logic          ld_stall_o,
  output logic [DW-1:0] ld_data_o,
  output logic          own_req_valid_o,
  input  logic          own_req_ready_i,
  output logic [LW-1:0] own_req_line_o,
  input  logic          own_gnt_valid_i,
  input  logic [LW-1:0] own_gnt_line_i,
  output logic          cm_valid_o,
  input  logic          cm_ready_i,
  output logic [AW-1:0] cm_addr_o,
  output logic [DW-1:0] cm_data_o,
  output logic [MW-1:0] cm_mask_o
);
  import sb_pkg::*;

  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [MW-1:0] mask_q [DEPTH];
  sb_flags_t     flg_q  [DEPTH];
  logic [IW-1:0] head_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] ret_cnt_q;   // retired entries form a prefix from head

  // age-ordered views
  logic [DEPTH-1:0] age_vld;
  logic [AW-1:0]    age_addr [DEPTH];
  logic [DW-1:0]    age_data [DEPTH];
  logic [MW-1:0]    age_mask [DEPTH];
  sb_flags_t        age_flg  [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  logic [IW-1:0]    slot_age [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [IW-1:0] slot;
    assign slot        = head_q + IW'(k);
    assign age_vld[k]  = CW'(k) < count_q;
    assign age_addr[k] = addr_q[slot];
    assign age_data[k] = data_q[slot];
    assign age_mask[k] = mask_q[slot];
    assign age_flg[k]  = flg_q[slot];
    assign slot_age[k] = IW'(k) - head_q;
    assign slot_vld[k] = CW'(slot_age[k]) < count_q;
  end

  sb_fwd_unit #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) fwd_i (
    .vld_i      (age_vld),
    .addr_i     (age_addr),
    .data_i     (age_data),
    .mask_i     (age_mask),
    .ld_valid_i (ld_valid_i),
    .ld_addr_i  (ld_addr_i),
    .ld_mask_i  (ld_mask_i),
    .hit_o      (ld_hit_o),
    .stall_o    (ld_stall_o),
    .data_o     (ld_data_o)
  );

  logic [IW-1:0] req_age;
  sb_req_pick #(.DEPTH(DEPTH), .AW(AW), .LINE_W(LINE_W)) pick_i (
    .vld_i       (age_vld),
    .flags_i     (age_flg),
    .addr_i      (age_addr),
    .req_valid_o (own_req_valid_o),
    .req_age_o   (req_age),
    .req_line_o  (own_req_line_o)
  );

  logic          req_fire, st_fire, cm_fire, ret_do;
  logic [IW-1:0] req_slot, tail;
  logic [CW-1:0] ret_next;

  assign st_ready_o = !flush_i && (count_q < CW'(DEPTH));
  assign st_fire    = st_valid_i && st_ready_o;
  assign req_fire   = own_req_valid_o && own_req_ready_i;
  assign req_slot   = head_q + req_age;
  assign tail       = head_q + count_q[IW-1:0];

  assign cm_valid_o = (ret_cnt_q != '0) && flg_q[head_q].owned;
  assign cm_addr_o  = addr_q[head_q];
  assign cm_data_o  = data_q[head_q];
  assign cm_mask_o  = mask_q[head_q];
  assign cm_fire    = cm_valid_o && cm_ready_i;

  assign ret_do   = retire_i && (ret_cnt_q < count_q);
  assign ret_next = ret_cnt_q + CW'(ret_do) - CW'(cm_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q    <= '0;
      count_q   <= '0;
      ret_cnt_q <= '0;
    end else begin
      head_q    <= head_q + IW'(cm_fire);
      ret_cnt_q <= ret_next;
      count_q   <= flush_i ? ret_next : count_q + CW'(st_fire) - CW'(cm_fire);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) begin
        addr_q[s] <= '0;
        data_q[s] <= '0;
        mask_q[s] <= '0;
        flg_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (st_fire && tail == IW'(s)) begin
          addr_q[s]       <= st_addr_i;
          data_q[s]       <= st_data_i;
          mask_q[s]       <= st_mask_i;
          flg_q[s].owned  <= own_gnt_valid_i && st_addr_i[AW-1:LINE_W] == own_gnt_line_i;
          flg_q[s].asked  <= 1'b0;
        end else begin
          if (own_gnt_valid_i && slot_vld[s] && addr_q[s][AW-1:LINE_W] == own_gnt_line_i)
            flg_q[s].owned <= 1'b1;
          if (req_fire && req_slot == IW'(s))
            flg_q[s].asked <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sb_store_buffer_chk.sv
module sb_store_buffer_chk #(
  parameter int unsigned DEPTH  = sb_pkg::SB_DEPTH,
  parameter int unsigned AW     = sb_pkg::SB_AW,
  parameter int unsigned DW     = sb_pkg::SB_DW,
  parameter int unsigned LINE_W = sb_pkg::SB_LINE_W,
  localparam int unsigned LW    = AW - LINE_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_ready_o,
  input logic          retire_i,
  input logic          flush_i,
  input logic          ld_hit_o,
  input logic          ld_stall_o,
  input logic          own_req_valid_o,
  input logic          own_req_ready_i,
  input logic [LW-1:0] own_req_line_o,
  input logic          own_gnt_valid_i,
  input logic          cm_valid_o,
  input logic          cm_ready_i,
  input logic [AW-1:0] cm_addr_o,
  input logic [DW-1:0] cm_data_o,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] ret_cnt_q
);
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  // R2
  push_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o && !cm_valid_o |=> count_q == $past(count_q) + CW'(1));

  // R4
  hit_stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && ld_stall_o));

  // R5
  commit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_valid_o && !cm_ready_i |=> cm_valid_o && $stable(cm_addr_o) && $stable(cm_data_o));

  // R7
  flush_keeps_retired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !retire_i && !(cm_valid_o && cm_ready_i) |=> count_q == $past(ret_cnt_q));

  // R12
  retired_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_cnt_q <= count_q);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_req_valid_o && !own_req_ready_i && !flush_i && !own_gnt_valid_i
    |=> own_req_valid_o && $stable(own_req_line_o));
endmodule

bind sb_store_buffer sb_store_buffer_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_W(LINE_W)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .st_valid_i      (st_valid_i),
  .st_ready_o      (st_ready_o),
  .retire_i        (retire_i),
  .flush_i         (flush_i),
  .ld_hit_o        (ld_hit_o),
  .ld_stall_o      (ld_stall_o),
  .own_req_valid_o (own_req_valid_o),
  .own_req_ready_i (own_req_ready_i),
  .own_req_line_o  (own_req_line_o),
  .own_gnt_valid_i (own_gnt_valid_i),
  .cm_valid_o      (cm_valid_o),
  .cm_ready_i      (cm_ready_i),
  .cm_addr_o       (cm_addr_o),
  .cm_data_o       (cm_data_o),
  .count_q         (count_q),
  .ret_cnt_q       (ret_cnt_q)
);

// File: tb/sb_store_buffer_tb_top.sv
`timescale 1ns/1ps
module sb_store_buffer_tb_top;
  localparam int AW = 16, DW = 32, MW = 4, LW = 14, DEPTH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni;
  logic          st_valid, st_ready, retire, flush, ld_valid;
  logic [AW-1:0] st_addr, ld_addr;
  logic [DW-1:0] st_data;
  logic [MW-1:0] st_mask, ld_mask;
  logic          ld_hit, ld_stall;
  logic [DW-1:0] ld_data;
  logic          rq_valid, rq_ready, gnt_valid;
  logic [LW-1:0] rq_line, gnt_line;
  logic          cm_valid, cm_ready;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;
  logic [MW-1:0] cm_mask;

  sb_store_buffer dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_mask_i(st_mask),
    .retire_i(retire), .flush_i(flush),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_mask_i(ld_mask),
    .ld_hit_o(ld_hit), .ld_stall_o(ld_stall), .ld_data_o(ld_data),
    .own_req_valid_o(rq_valid), .own_req_ready_i(rq_ready), .own_req_line_o(rq_line),
    .own_gnt_valid_i(gnt_valid), .own_gnt_line_i(gnt_line),
    .cm_valid_o(cm_valid), .cm_ready_i(cm_ready),
    .cm_addr_o(cm_addr), .cm_data_o(cm_data), .cm_mask_o(cm_mask)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [MW-1:0] m;
    bit ret, own, req;
  } ment_t;
  ment_t mq[$];

  int total = 0, bad = 0;
  bit done = 1'b0;
  string ph = "R1";

  bit e_st_ready, e_cm_valid, e_rq_valid, e_hit, e_stall;
  int e_rq_idx;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] act=%h exp=%h t=%0t", tag, ph, act, exp, $time);
    end
  endtask

  task automatic compare();
    int y;
    e_st_ready = !flush && mq.size() < DEPTH;
    e_cm_valid = mq.size() > 0 && mq[0].ret && mq[0].own;
    e_rq_valid = 1'b0; e_rq_idx = 0;
    foreach (mq[i]) if (!e_rq_valid && !mq[i].own && !mq[i].req) begin
      e_rq_valid = 1'b1; e_rq_idx = i;
    end
    y = -1;
    foreach (mq[i]) if (mq[i].a == ld_addr) y = i;
    e_hit   = ld_valid && y >= 0 && (ld_mask & ~mq[y].m) == 0;
    e_stall = ld_valid && y >= 0 && !e_hit;
    chk(st_ready == e_st_ready, "R2 st_ready", st_ready, e_st_ready);
    chk(cm_valid == e_cm_valid, "R5 cm_valid", cm_valid, e_cm_valid);
    if (e_cm_valid)
      chk({cm_addr, cm_data, cm_mask} == {mq[0].a, mq[0].d, mq[0].m}, "R8 commit fields",
          {cm_addr, cm_data, cm_mask}, {mq[0].a, mq[0].d, mq[0].m});
    chk(rq_valid == e_rq_valid, "R9 req_valid", rq_valid, e_rq_valid);
    if (e_rq_valid)
      chk(rq_line == mq[e_rq_idx].a[AW-1:2], "R9 req_line", rq_line, mq[e_rq_idx].a[AW-1:2]);
    chk(ld_hit == e_hit, "R3 ld_hit", ld_hit, e_hit);
    chk(ld_stall == e_stall, "R4 ld_stall", ld_stall, e_stall);
    if (e_hit) chk(ld_data == mq[y].d, "R3 ld_data", ld_data, mq[y].d);
  endtask

  task automatic model_step();
    ment_t n;
    if (e_rq_valid && rq_ready) mq[e_rq_idx].req = 1'b1;
    if (gnt_valid) foreach (mq[i]) if (mq[i].a[AW-1:2] == gnt_line) mq[i].own = 1'b1;
    if (retire) begin
      for (int i = 0; i < mq.size(); i++) if (!mq[i].ret) begin mq[i].ret = 1'b1; break; end
    end
    if (e_cm_valid && cm_ready) void'(mq.pop_front());
    if (flush) while (mq.size() > 0 && !mq[mq.size()-1].ret) void'(mq.pop_back());
    if (e_st_ready && st_valid) begin
      n.a = st_addr; n.d = st_data; n.m = st_mask; n.ret = 1'b0; n.req = 1'b0;
      n.own = gnt_valid && st_addr[AW-1:2] == gnt_line;
      mq.push_back(n);
    end
  endtask

  // inputs are set at the negedge before this call
  task automatic step();
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    st_valid = 0; retire = 0; flush = 0; ld_valid = 0; rq_ready = 0;
    gnt_valid = 0; cm_ready = 0; st_addr = 0; st_data = 0; st_mask = 0;
    ld_addr = 0; ld_mask = 0; gnt_line = 0;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
    st_valid = 1; st_addr = a; st_data = d; st_mask = m;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [MW-1:0] m);
    ld_valid = 1; ld_addr = a; ld_mask = m;
    step();
    ld_valid = 0;
  endtask

  initial begin
    idle();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    ph = "R1";
    step();
    rst_ni = 1;
    step();

    // R2 fill without grants, requests accepted (R9)
    ph = "R2 fill";
    rq_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      push(AW'(i), 32'hA000_0000 + i, 4'hF);
      step();
    end
    push(16'h0009, 32'hDEAD, 4'hF);
    step();
    st_valid = 0; rq_ready = 0;

    // R3 / R4 forwarding in a full queue
    ph = "R3 fwd";
    load(16'h0003, 4'hF);
    load(16'h0005, 4'h3);
    load(16'h0064, 4'hF);

    // R6 retire three, not owned: they stay and forward
    ph = "R6 retire";
    cm_ready = 1;
    retire = 1;
    repeat (3) step();
    retire = 0;
    load(16'h0001, 4'hF);

    // R7 flush drops the five unretired stores
    ph = "R7 flush";
    flush = 1;
    push(16'h0020, 32'h1, 4'hF);
    step();
    flush = 0; st_valid = 0;
    load(16'h0006, 4'hF);

    // R11 grant for flushed line 1 changes nothing
    ph = "R11 stale grant";
    gnt_valid = 1; gnt_line = 14'd1;
    step();
    gnt_valid = 0;
    push(16'h0004, 32'hB4, 4'h1);
    step();
    st_valid = 0;
    rq_ready = 1;
    step();

    // R10 grant line 0, R5/R8 drain in order
    ph = "R10 grant";
    gnt_valid = 1; gnt_line = 14'd0;
    push(16'h0002, 32'hC2, 4'h2);
    step();
    gnt_valid = 0; st_valid = 0; rq_ready = 0;
    ph = "R8 drain";
    load(16'h0002, 4'h3);
    repeat (5) step();

    // R12 retire with flush, and retire with nothing to retire
    ph = "R12";
    push(16'h0030, 32'hE0, 4'hF); step();
    push(16'h0031, 32'hE1, 4'hF); step();
    st_valid = 0;
    retire = 1; flush = 1;
    step();
    flush = 0;
    repeat (4) step();
    retire = 0;
    gnt_valid = 1; gnt_line = 14'hC;
    step();
    gnt_valid = 0;
    repeat (3) step();
    // grant in same cycle as a store to that line (R10)
    ph = "R10 same cycle";
    gnt_valid = 1; gnt_line = 14'h5; push(16'h0015, 32'h55, 4'hF);
    step();
    idle(); retire = 1; cm_ready = 1;
    repeat (3) step();

    // random mix
    ph = "random";
    for (int c = 0; c < 6000; c++) begin
      st_valid = ($urandom % 2) == 0;
      st_addr  = AW'($urandom % 16);
      st_data  = $urandom;
      st_mask  = MW'($urandom);
      retire   = ($urandom % 10) < 3;
      flush    = ($urandom % 40) == 0;
      ld_valid = ($urandom % 10) < 6;
      ld_addr  = AW'($urandom % 16);
      ld_mask  = MW'($urandom);
      cm_ready = ($urandom % 10) < 6;
      rq_ready = ($urandom % 2) == 0;
      gnt_valid = ($urandom % 10) < 3;
      gnt_line = LW'($urandom % 5);
      if ($urandom % 2 == 0)
        foreach (mq[i]) if (mq[i].req && !mq[i].own) begin gnt_line = mq[i].a[AW-1:2]; break; end
      step();
    end
    idle();
    repeat (2) step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog [%s] act=%h exp=%h", ph, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule